// File: doc/BRIEF.md
# Pulse-Driven Level Decoder with Loss-of-Signal Watchdog

This block sits on the receiving side of a pulse-coded signal path. For every lane it gets two single-cycle strobes: a "set" strobe that marks a rising transition and a "clear" strobe that marks a falling transition. From these strobes it rebuilds the logic level. The rebuilt level holds between strobes. The sender also repeats strobes that match the current level, so the output stays correct when the input does not change. Those repeated strobes leave the output unchanged.

Each lane has a watchdog that counts clock cycles since the last valid strobe. If the count reaches `WDOG_CYCLES` with no valid strobe, the lane treats the sender as unpowered or broken. It then forces its level low and raises `timeout`. The first valid strobe after that restores normal tracking. `WDOG_CYCLES` must be set longer than the sender's repeat interval.

After reset every lane starts as though the sender had not yet started: the level is low and the watchdog is already expired. All outputs are registered.

Top module: `pulse_level_decoder`

## Requirements
- R1: After a synchronous reset, every lane has `level_out` = 0 and `timeout` = 1.
- R2: A cycle in which a lane's set bit is 1 and its clear bit is 0 is a valid set strobe. At the next clock edge `level_out` becomes 1 and `timeout` becomes 0.
- R3: A cycle in which a lane's clear bit is 1 and its set bit is 0 is a valid clear strobe. At the next clock edge `level_out` becomes 0 and `timeout` becomes 0.
- R4: While the watchdog has not expired, `level_out` keeps its value across cycles with no strobe. A repeated strobe that matches the present level leaves `level_out` unchanged.
- R5: A cycle in which a lane's set and clear bits are both 1 is illegal and is ignored. `level_out` keeps its value unless the watchdog expires at that edge, and the watchdog is not reloaded.
- R6: Let the edge that takes a valid strobe be edge k. If no valid strobe arrives at edges k+1 through k+WDOG_CYCLES, then at edge k+WDOG_CYCLES `timeout` becomes 1 and `level_out` becomes 0. Strobes spaced exactly WDOG_CYCLES apart never cause a timeout.
- R7: The watchdog count saturates and does not wrap. Without a valid strobe, `timeout` stays 1 and `level_out` stays 0 for as long as the silence lasts.
- R8: The first valid strobe after a timeout clears `timeout` and sets `level_out` to the level that strobe indicates, both at the next clock edge.
- R9: Lanes are independent: the strobes on one lane have no effect on the level or watchdog of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_strb | input | LANES | Per-lane set strobe, one cycle per pulse |
| clr_strb | input | LANES | Per-lane clear strobe, one cycle per pulse |
| level_out | output | LANES | Rebuilt logic level per lane, registered |
| timeout | output | LANES | Per-lane watchdog-expired flag, registered |

## Verification
Every result is due one clock edge after the strobe that causes it. A timeout is due exactly WDOG_CYCLES edges after the edge that took the last valid strobe. The bench drives inputs on the falling edge and compares both outputs of both lanes shortly after each rising edge. It uses a per-cycle arithmetic model built from the requirements, so an early or late change is reported at the exact cycle where it appears. A sweep combines every strobe code on each lane with idle gaps from zero up to two cycles beyond the timeout, so spacings of WDOG_CYCLES-1, WDOG_CYCLES and WDOG_CYCLES+1 are all exercised.

// File: rtl/pld_pkg.sv
package pld_pkg;

  // Strobe code per lane, formed as {clear, set}
  typedef enum logic [1:0] {
    EV_IDLE  = 2'b00,
    EV_SET   = 2'b01,
    EV_CLR   = 2'b10,
    EV_CLASH = 2'b11
  } pulse_ev_e;

  function automatic pulse_ev_e classify(input logic s, input logic c);
    return pulse_ev_e'({c, s});
  endfunction

  function automatic logic is_valid(input pulse_ev_e ev);
    return (ev == EV_SET) || (ev == EV_CLR);
  endfunction

endpackage

// File: rtl/lane_wdog.sv
module lane_wdog #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  output logic expire_d,
  output logic expired_q
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (reload)
      cnt_d = '0;
    else if (cnt_q != LIM_V)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  assign expire_d = (cnt_d == LIM_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= LIM_V;
      expired_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      expired_q <= expire_d;
    end
  end

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LIM_V && !reload) |=> (cnt_q == LIM_V && expired_q));

  a_r8_reload_clears: assert property (@(posedge clk) disable iff (rst)
    reload |=> (!expired_q && cnt_q == '0));

endmodule

// File: rtl/lane_latch.sv
module lane_latch
  import pld_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pulse_ev_e ev,
  input  logic      force_low,
  output logic      level_q
);
  always_ff @(posedge clk) begin
    if (rst)
      level_q <= 1'b0;
    else begin
      unique case (ev)
        EV_SET:  level_q <= 1'b1;
        EV_CLR:  level_q <= 1'b0;
        default: if (force_low) level_q <= 1'b0;
      endcase
    end
  end

  a_r2_set_high: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_SET) |=> level_q);

  a_r3_clr_low: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_CLR) |=> !level_q);

  a_r5_clash_hold: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_CLASH && !force_low) |=> $stable(level_q));

endmodule

// File: rtl/pulse_level_decoder.sv
module pulse_level_decoder
  import pld_pkg::*;
#(
  parameter int LANES       = 2,
  parameter int WDOG_CYCLES = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] set_strb,
  input  logic [LANES-1:0] clr_strb,
  output logic [LANES-1:0] level_out,
  output logic [LANES-1:0] timeout
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pulse_ev_e ev;
    logic      reload;
    logic      expire_d;

    assign ev     = classify(set_strb[i], clr_strb[i]);
    assign reload = is_valid(ev);

    lane_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
      .clk       (clk),
      .rst       (rst),
      .reload    (reload),
      .expire_d  (expire_d),
      .expired_q (timeout[i])
    );

    lane_latch u_latch (
      .clk       (clk),
      .rst       (rst),
      .ev        (ev),
      .force_low (expire_d),
      .level_q   (level_out[i])
    );

    a_r6_timeout_low: assert property (@(posedge clk) disable iff (rst)
      timeout[i] |-> !level_out[i]);

    a_r4_hold_quiet: assert property (@(posedge clk) disable iff (rst)
      (!set_strb[i] && !clr_strb[i]) |=> (timeout[i] || $stable(level_out[i])));

    a_r8_recover: assert property (@(posedge clk) disable iff (rst)
      (timeout[i] && (set_strb[i] ^ clr_strb[i])) |=> (!timeout[i] && (level_out[i] == $past(set_strb[i]))));
  end

endmodule

// File: tb/sim_pulse_level_decoder.sv
module sim_pulse_level_decoder;
  localparam int LN = 2;
  localparam int W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LN-1:0] set_strb = '0;
  logic [LN-1:0] clr_strb = '0;
  logic [LN-1:0] level_out;
  logic [LN-1:0] timeout;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // bench model state, built from the requirements
  int   m_cnt [LN];
  logic m_lvl [LN];
  logic m_to  [LN];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  pulse_level_decoder #(.LANES(LN), .WDOG_CYCLES(W)) u0 (
    .clk(clk), .rst(rst), .set_strb(set_strb), .clr_strb(clr_strb),
    .level_out(level_out), .timeout(timeout)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic tick(input logic [LN-1:0] s, input logic [LN-1:0] c);
    string tag [LN];
    @(negedge clk);
    set_strb = s;
    clr_strb = c;
    @(posedge clk);
    for (int i = 0; i < LN; i++) begin
      logic valid;
      logic was_to;
      valid  = s[i] ^ c[i];
      was_to = m_to[i];
      if (valid) begin
        m_lvl[i] = s[i];
        m_cnt[i] = 0;
        m_to[i]  = 1'b0;
        tag[i] = was_to ? "R8" : (s[i] ? "R2" : "R3");
      end else begin
        if (m_cnt[i] != W) m_cnt[i]++;
        m_to[i] = (m_cnt[i] == W);
        if (m_to[i]) m_lvl[i] = 1'b0;
        if (s[i] && c[i])       tag[i] = "R5";
        else if (was_to)        tag[i] = "R7";
        else if (m_to[i])       tag[i] = "R6";
        else                    tag[i] = "R4";
      end
    end
    // lane 1 idle while lane 0 takes a valid strobe: cross-lane isolation (R9)
    if ((s[0] ^ c[0]) && !s[1] && !c[1]) tag[1] = "R9";
    #2;
    for (int i = 0; i < LN; i++) begin
      chk(tag[i], "level_out", level_out[i], m_lvl[i]);
      chk(tag[i], "timeout",   timeout[i],   m_to[i]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < LN; i++) begin
      m_cnt[i] = W; m_lvl[i] = 1'b0; m_to[i] = 1'b1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int i = 0; i < LN; i++) begin
      chk("R1", "level_out", level_out[i], 1'b0);
      chk("R1", "timeout",   timeout[i],   1'b1);
    end
    // silence right after reset stays in timeout (R7)
    repeat (3) tick('0, '0);
    // recovery from reset state (R8)
    tick(2'b01, 2'b10);
    // matching repeated strobes cause no change (R4)
    repeat (4) begin tick(2'b01, 2'b10); tick('0, '0); end
    // spacing exactly W never times out (R6)
    for (int k = 0; k < 3; k++) begin
      tick(2'b11, 2'b00);
      repeat (W - 1) tick('0, '0);
    end
    // clash ignored while active (R5)
    tick(2'b11, 2'b11);
    tick('0, '0);
    // sweep: every code on each lane, gaps up to W+2
    for (int gap = 0; gap <= W + 2; gap++) begin
      for (int a = 0; a < 4; a++) begin
        logic [1:0] b;
        b = 2'((a + gap) % 4);
        tick({b[0], a[0]}, {b[1], a[1]});
        repeat (gap) tick('0, '0);
      end
    end
    // long silence, saturation (R7), then recovery with clear (R8)
    tick(2'b11, 2'b00);
    repeat (3 * W) tick('0, '0);
    tick(2'b00, 2'b11);
    tick(2'b11, 2'b11);
    repeat (W + 1) tick('0, '0);
    // reset mid-operation restores the reset state (R1)
    tick(2'b11, 2'b00);
    @(negedge clk); rst = 1'b1; set_strb = '0; clr_strb = '0;
    @(negedge clk); rst = 1'b0;
    #1;
    for (int i = 0; i < LN; i++) begin
      chk("R1", "level_out", level_out[i], 1'b0);
      chk("R1", "timeout",   timeout[i],   1'b1);
      m_cnt[i] = W; m_lvl[i] = 1'b0; m_to[i] = 1'b1;
    end
    tick(2'b10, 2'b01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule